// File: doc/BRIEF.md
# Timer Slave Trigger Controller

This block lets one timer follow the trigger outputs of other timers. A 32-bit slave control word chooses one of 32 internal trigger lines and an action mode. The block watches the chosen line for rising edges. Depending on the mode, each edge asks the host timer to reinitialise its counter and raise an update event, to start a stopped counter, or to do both.

Every output is a one-cycle registered strobe, so each one appears on the clock edge after the edge on the trigger line is seen. A reinitialise strobe comes with the value the counter should load and the repetition count to reload. The host timer owns the counter itself. It reports back whether the counter is running and in which direction it counts, and it supplies its auto-reload value and repetition setting.

Top module: `slave_trig_top`

## Requirements
- R1: The mode is bits 2:0 of `ctrlWord` as its low three bits with bit 16 as bit 3. The values are 0 disabled, 1 to 3 encoder, 4 reset, 5 gated, 6 trigger, 7 external clock and 8 combined reset and trigger.
- R2: The source index is bits 6:4 of `ctrlWord` as its low three bits with bits 21:20 as bits 4:3. It selects bit `index` of `trigLines`.
- R3: Only a rising edge of the selected line acts. A falling edge produces no strobe.
- R4: Edges on any line other than the selected one produce no strobe.
- R5: In reset mode (4), a rising edge sampled at one clock edge drives `reinitPulse` and `updatePulse` high for exactly the following cycle, with `startReq` low.
- R6: In trigger mode (6), an edge raises `startReq` for one cycle when `counterRunning` is low and `reloadValue` is non-zero. When the counter is running there is no strobe at all.
- R7: A start is refused (no `startReq`) whenever `reloadValue` is zero, in both trigger mode and combined mode.
- R8: In combined mode (8), an edge raises `reinitPulse` and `updatePulse`. It also raises `startReq` when the counter is stopped and `reloadValue` is non-zero.
- R9: With a reinitialise strobe, `loadCount` is 0 when `countDown` is low and `reloadValue` when it is high, and `loadRep` equals `repCount`. Both values hold until the next reinitialise.
- R10: Modes 0, 1, 2, 3, 5, 7 and any value above 8 ignore every edge.
- R11: A change of the source index does not count as an edge in the cycle of the change, even when the newly selected line is already high.
- R12: After reset all strobes are low and `loadCount` and `loadRep` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Slave control word holding the split mode and source fields |
| trigLines | input | 32 | Internal trigger lines from other timers |
| counterRunning | input | 1 | High while the host counter is enabled |
| countDown | input | 1 | High when the host counter counts down |
| reloadValue | input | CNT_W (16) | Host auto-reload value |
| repCount | input | REP_W (8) | Host repetition setting |
| reinitPulse | output | 1 | One-cycle request to reinitialise the counter |
| updatePulse | output | 1 | One-cycle update event request |
| startReq | output | 1 | One-cycle request to enable the counter |
| loadCount | output | CNT_W (16) | Value to load into the counter on reinitialise |
| loadRep | output | REP_W (8) | Repetition count to reload on reinitialise |

## Verification
The edge detection is tried with a clean pulse on the selected line, a pulse on a different line, and a line that is already high when it becomes selected or that falls while selected. These patterns separate true rising edges from level sensitivity, from falling-edge sensitivity and from false edges caused by a source change. A source index above 7 checks that the upper source bits are decoded, because the same low bits with the upper bits dropped would name another line. Each mode is driven with the counter stopped and then running, and with a zero and a non-zero reload value. This shows which modes start the counter, which modes reset it and which modes do nothing. Up and down counting check the value loaded on reinitialise.

// File: rtl/slave_trig_pkg.sv
package slave_trig_pkg;

  typedef enum logic [3:0] {
    SM_OFF    = 4'd0,
    SM_ENC_A  = 4'd1,
    SM_ENC_B  = 4'd2,
    SM_ENC_C  = 4'd3,
    SM_RESET  = 4'd4,
    SM_GATED  = 4'd5,
    SM_TRIG   = 4'd6,
    SM_EXTCLK = 4'd7,
    SM_COMBO  = 4'd8
  } slaveMode_e;

  typedef struct packed {
    logic reinit;
    logic update;
    logic start;
  } slaveCmd_t;

  localparam int SRC_W  = 5;
  localparam int MODE_W = 4;

endpackage

// File: rtl/slave_trig_ctrl.sv
module slave_trig_ctrl
  import slave_trig_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [31:0]          ctrlWord,
  input  logic [NUM_LINES-1:0] trigLines,
  input  logic                 counterRunning,
  input  logic                 reloadNonZero,
  output slaveCmd_t            cmd
);

  logic [MODE_W-1:0] modeRaw;
  logic [SRC_W-1:0]  srcIdx;
  logic [SRC_W-1:0]  srcQ;
  logic              selLevel;
  logic              prevLevel;
  logic              riseSeen;
  slaveMode_e        mode;
  logic              unusedCtrlBits;

  assign modeRaw = {ctrlWord[16], ctrlWord[2:0]};
  assign srcIdx  = {ctrlWord[21:20], ctrlWord[6:4]};
  assign unusedCtrlBits = ^{ctrlWord[31:22], ctrlWord[19:17], ctrlWord[15:7], ctrlWord[3]};

  always_comb begin
    selLevel = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (srcIdx == SRC_W'(i)) selLevel = trigLines[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= 1'b0;
      srcQ      <= '0;
    end else begin
      prevLevel <= selLevel;
      srcQ      <= srcIdx;
    end
  end

  // a source change re-samples the level instead of reporting an edge
  assign riseSeen = selLevel && !prevLevel && (srcIdx == srcQ);

  always_comb begin
    mode = SM_OFF;
    case (modeRaw)
      4'd4:    mode = SM_RESET;
      4'd6:    mode = SM_TRIG;
      4'd8:    mode = SM_COMBO;
      default: mode = SM_OFF;
    endcase
  end

  always_comb begin
    cmd = '0;
    if (riseSeen) begin
      case (mode)
        SM_RESET: begin
          cmd.reinit = 1'b1;
          cmd.update = 1'b1;
        end
        SM_TRIG: begin
          cmd.start = !counterRunning && reloadNonZero;
        end
        SM_COMBO: begin
          cmd.reinit = 1'b1;
          cmd.update = 1'b1;
          cmd.start  = !counterRunning && reloadNonZero;
        end
        default: cmd = '0;
      endcase
    end
  end

endmodule

// File: rtl/slave_trig_dp.sv
module slave_trig_dp
  import slave_trig_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  slaveCmd_t        cmd,
  input  logic             countDown,
  input  logic [CNT_W-1:0] reloadValue,
  input  logic [REP_W-1:0] repCount,
  output logic             reinitPulse,
  output logic             updatePulse,
  output logic             startReq,
  output logic [CNT_W-1:0] loadCount,
  output logic [REP_W-1:0] loadRep
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reinitPulse <= 1'b0;
      updatePulse <= 1'b0;
      startReq    <= 1'b0;
      loadCount   <= '0;
      loadRep     <= '0;
    end else begin
      reinitPulse <= cmd.reinit;
      updatePulse <= cmd.update;
      startReq    <= cmd.start;
      if (cmd.reinit) begin
        loadCount <= countDown ? reloadValue : '0;
        loadRep   <= repCount;
      end
    end
  end

endmodule

// File: rtl/slave_trig_top.sv
module slave_trig_top
  import slave_trig_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int CNT_W     = 16,
  parameter int REP_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [31:0]          ctrlWord,
  input  logic [NUM_LINES-1:0] trigLines,
  input  logic                 counterRunning,
  input  logic                 countDown,
  input  logic [CNT_W-1:0]     reloadValue,
  input  logic [REP_W-1:0]     repCount,
  output logic                 reinitPulse,
  output logic                 updatePulse,
  output logic                 startReq,
  output logic [CNT_W-1:0]     loadCount,
  output logic [REP_W-1:0]     loadRep
);

  slaveCmd_t cmd;

  slave_trig_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .ctrlWord       (ctrlWord),
    .trigLines      (trigLines),
    .counterRunning (counterRunning),
    .reloadNonZero  (reloadValue != '0),
    .cmd            (cmd)
  );

  slave_trig_dp #(.CNT_W(CNT_W), .REP_W(REP_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .countDown   (countDown),
    .reloadValue (reloadValue),
    .repCount    (repCount),
    .reinitPulse (reinitPulse),
    .updatePulse (updatePulse),
    .startReq    (startReq),
    .loadCount   (loadCount),
    .loadRep     (loadRep)
  );

endmodule

// File: rtl/slave_trig_chk.sv
module slave_trig_chk #(
  parameter int NUM_LINES = 32,
  parameter int CNT_W     = 16,
  parameter int REP_W     = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [31:0]          ctrlWord,
  input logic [NUM_LINES-1:0] trigLines,
  input logic                 counterRunning,
  input logic                 countDown,
  input logic [CNT_W-1:0]     reloadValue,
  input logic [REP_W-1:0]     repCount,
  input logic                 reinitPulse,
  input logic                 updatePulse,
  input logic                 startReq,
  input logic [CNT_W-1:0]     loadCount,
  input logic [REP_W-1:0]     loadRep
);

  logic [3:0] modeNow;
  logic [4:0] srcNow;
  logic       selNow;
  logic [1:0] warmCnt;
  logic       warm;
  logic       unusedChk;

  assign modeNow = {ctrlWord[16], ctrlWord[2:0]};
  assign srcNow  = {ctrlWord[21:20], ctrlWord[6:4]};
  assign selNow  = (32'(srcNow) < NUM_LINES) ? trigLines[srcNow] : 1'b0;
  assign unusedChk = ^{ctrlWord[31:22], ctrlWord[19:17], ctrlWord[15:7], ctrlWord[3], loadRep, repCount};
  assign warm = (warmCnt == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) warmCnt <= '0;
    else if (!warm) warmCnt <= warmCnt + 2'd1;
  end

  // R3 strobe only after the selected line went from low to high
  assert_rising_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (warm && (reinitPulse || startReq)) |-> ($past(selNow) && !$past(selNow, 2)));

  // R5 reinitialise and update travel together
  assert_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    reinitPulse |-> updatePulse);

  // R6 no start of a running counter
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> !$past(counterRunning));

  // R7 start needs a non-zero reload value
  assert_zero_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> ($past(reloadValue) != '0));

  // R10 strobes only from supported modes
  assert_mode_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reinitPulse || startReq) |-> ($past(modeNow) inside {4'd4, 4'd6, 4'd8}));

  // R9 down-counting reinitialise loads the reload value
  assert_load_down_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reinitPulse && $past(countDown)) |-> (loadCount == $past(reloadValue)));

  // R9 up-counting reinitialise loads zero
  assert_load_up_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reinitPulse && !$past(countDown)) |-> (loadCount == '0));

endmodule

bind slave_trig_top slave_trig_chk #(
  .NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .REP_W(REP_W)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .ctrlWord       (ctrlWord),
  .trigLines      (trigLines),
  .counterRunning (counterRunning),
  .countDown      (countDown),
  .reloadValue    (reloadValue),
  .repCount       (repCount),
  .reinitPulse    (reinitPulse),
  .updatePulse    (updatePulse),
  .startReq       (startReq),
  .loadCount      (loadCount),
  .loadRep        (loadRep)
);

// File: tb/slave_trig_top_tb.sv
module slave_trig_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [31:0] trigLines = '0;
  logic        counterRunning = 1'b0;
  logic        countDown = 1'b0;
  logic [15:0] reloadValue = 16'd1000;
  logic [7:0]  repCount = 8'd0;
  logic        reinitPulse, updatePulse, startReq;
  logic [15:0] loadCount;
  logic [7:0]  loadRep;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_trig_top u_dut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .trigLines(trigLines),
    .counterRunning(counterRunning), .countDown(countDown),
    .reloadValue(reloadValue), .repCount(repCount),
    .reinitPulse(reinitPulse), .updatePulse(updatePulse), .startReq(startReq),
    .loadCount(loadCount), .loadRep(loadRep)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input logic [3:0] mode, input logic [4:0] src);
    logic [31:0] w = '0;
    w[2:0]   = mode[2:0];
    w[16]    = mode[3];
    w[6:4]   = src[2:0];
    w[21:20] = src[4:3];
    return w;
  endfunction

  task automatic setCfg(input logic [3:0] mode, input logic [4:0] src);
    @(negedge clk);
    ctrlWord = mkCfg(mode, src);
    @(negedge clk);
    @(negedge clk);
  endtask

  // pulse one line; return strobes in the cycle after the rise and any strobe afterwards
  task automatic fire(input int idx, output logic [2:0] first, output logic [2:0] after);
    @(negedge clk);
    trigLines[idx] = 1'b1;
    @(negedge clk);
    first = {reinitPulse, updatePulse, startReq};
    @(negedge clk);
    after = {reinitPulse, updatePulse, startReq};
    trigLines[idx] = 1'b0;
    @(negedge clk);
    after = after | {reinitPulse, updatePulse, startReq};
    @(negedge clk);
    after = after | {reinitPulse, updatePulse, startReq};
  endtask

  task automatic testReset();
    check("R12 strobes after reset", {29'd0, reinitPulse, updatePulse, startReq}, 0);
    check("R12 loadCount after reset", loadCount, 0);
    check("R12 loadRep after reset", loadRep, 0);
  endtask

  task automatic testResetMode();
    logic [2:0] f, a;
    countDown = 0; repCount = 8'd5; counterRunning = 1;
    setCfg(4'd4, 5'd3);
    fire(3, f, a);
    check("R5 reset mode strobes", f, 3'b110);
    check("R3 R5 single cycle, no strobe on fall", a, 3'b000);
    check("R9 up-count load zero", loadCount, 0);
    check("R9 repetition reload", loadRep, 5);
    countDown = 1; repCount = 8'd9;
    fire(3, f, a);
    check("R9 down-count strobes", f, 3'b110);
    check("R9 down-count load reload", loadCount, 1000);
    check("R9 repetition reload down", loadRep, 9);
    countDown = 0;
    fire(3, f, a);
    check("R9 held value replaced", loadCount, 0);
  endtask

  task automatic testSelect();
    logic [2:0] f, a;
    counterRunning = 1;
    setCfg(4'd4, 5'd3);
    fire(7, f, a);
    check("R4 other line ignored", f | a, 3'b000);
    setCfg(4'd4, 5'd27);
    fire(3, f, a);
    check("R2 low bits alone do not select", f | a, 3'b000);
    fire(27, f, a);
    check("R2 split source 27 selects line 27", f, 3'b110);
    fire(19, f, a);
    check("R2 line 19 ignored for source 27", f | a, 3'b000);
  endtask

  task automatic testTrigger();
    logic [2:0] f, a;
    setCfg(4'd6, 5'd12);
    counterRunning = 0; reloadValue = 16'd1000;
    fire(12, f, a);
    check("R6 trigger starts stopped counter", f, 3'b001);
    check("R6 start is one cycle", a, 3'b000);
    counterRunning = 1;
    fire(12, f, a);
    check("R6 running counter undisturbed", f | a, 3'b000);
    counterRunning = 0; reloadValue = 16'd0;
    fire(12, f, a);
    check("R7 zero reload refuses start", f | a, 3'b000);
    reloadValue = 16'd1000;
  endtask

  task automatic testCombined();
    logic [2:0] f, a;
    countDown = 1; repCount = 8'd2;
    setCfg(4'd8, 5'd31);
    counterRunning = 0;
    fire(31, f, a);
    check("R1 R8 combined stopped", f, 3'b111);
    check("R8 load value", loadCount, 1000);
    counterRunning = 1;
    fire(31, f, a);
    check("R8 combined running", f, 3'b110);
    counterRunning = 0; reloadValue = 16'd0;
    fire(31, f, a);
    check("R7 R8 combined zero reload", f, 3'b110);
    check("R9 load zero reload value", loadCount, 0);
    reloadValue = 16'd1000; countDown = 0;
  endtask

  task automatic testIgnoredModes();
    logic [2:0] f, a;
    counterRunning = 0;
    foreach (ignoredList[i]) begin
      setCfg(ignoredList[i], 5'd6);
      fire(6, f, a);
      check($sformatf("R10 mode %0d ignored", ignoredList[i]), f | a, 3'b000);
    end
  endtask

  logic [3:0] ignoredList [9] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd7, 4'd9, 4'd12, 4'd14};

  task automatic testSourceChange();
    logic [2:0] seen;
    counterRunning = 1;
    setCfg(4'd4, 5'd2);
    @(negedge clk);
    trigLines[5] = 1'b1;
    @(negedge clk);
    ctrlWord = mkCfg(4'd4, 5'd5);
    seen = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      seen = seen | {reinitPulse, updatePulse, startReq};
    end
    check("R11 source change no false edge", seen, 3'b000);
    // falling edge while selected
    trigLines[5] = 1'b0;
    seen = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      seen = seen | {reinitPulse, updatePulse, startReq};
    end
    check("R3 falling edge ignored", seen, 3'b000);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testResetMode();
    testSelect();
    testTrigger();
    testCombined();
    testIgnoredModes();
    testSourceChange();
    done = 1;
    finishRun();
  end

endmodule